// File: doc/BRIEF.md
# Two-Wire Framed Serial Bus Controller

This block connects a chip to a two-wire synchronous serial bus made of a clock line and an open-drain data line. Set by a strap input, each instance runs as bus master or as slave. The master drives the clock. It can frame the next byte with two line conditions: a release marker and a command marker. Both conditions are data-line edges made while the clock is high. Ordinary data bits change only while the clock is low, so every device can decode these markers.

Every frame is 8 data bits, sent most significant bit first, and a ninth clock for the handshake. On the data line each device pulls low for its zero bits. The value on the line is therefore the wired-AND of every sender's byte. A device that has nothing to send leaves the line high. On the ninth clock a receiver can pull the line low as acknowledge. After that, a slave can keep the line low as busy, and the master then holds the clock low until the line returns high. Each completed frame is reported to the host as an address, a command or plain data, based on the markers seen before it. Sticky flags record the markers and handshakes that the device generated or detected.

Top module: `sbus_ctrl`

## Requirements
- R1: After reset, sck_out is 1, sb_pull is 0 and all six flags (rel_trig, cmd_trig, ack_trig, rel_det, cmd_det, ack_det) are 0.
- R2: When a master gets rel_req while idle, it makes SB rise while SCK is high and sets rel_trig. Every device that sees this edge sets rel_det.
- R3: Seeing a release condition clears cmd_det in the same update that sets rel_det.
- R4: When cmd_req is pending at the next transfer, the master first makes SB fall while SCK is high and sets cmd_trig. Every device that sees this edge sets cmd_det.
- R5: When a frame's 8th bit is taken in, rx_valid pulses for one cycle with rx_data. rx_kind is 2'b10 (address) if rel_det and cmd_det were both set, 2'b01 (command) if only cmd_det was set, and 2'b00 (data) otherwise.
- R6: A frame carries 8 bits, MSB first, and each bit is sampled on a rising SCK edge. A device's own drive changes only while SCK is low. rx_data equals the wired-AND of both senders' bytes, and a device with no byte written sends 8'hFF.
- R7: A device with auto_ack_en set, or with an ack_req still pending, pulls SB low for the ninth clock and sets ack_trig. A device that samples SB low at the ninth rising edge sets ack_det. If no device acknowledges, ack_det stays 0.
- R8: A slave with busy_en set keeps SB low after the acknowledge. While the master samples SB low after a frame, it keeps SCK low.
- R9: The slave releases busy when busy_en is cleared or when tx_we is pulsed. The master then drives SCK high again.
- R10: flag_clr clears all six flags. A flag set in the same cycle stays set.
- R11: A slave never pulls SCK low: sck_out stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| is_master | input | 1 | 1 selects master role |
| sck_in | input | 1 | Sampled level of the bus clock line |
| sck_out | output | 1 | Clock drive, open-drain (0 pulls low) |
| sb_in | input | 1 | Sampled level of the bus data line |
| sb_pull | output | 1 | 1 pulls the data line low |
| tx_we | input | 1 | Load tx_data; on a master, also start a frame |
| tx_data | input | 8 | Byte to send |
| rel_req | input | 1 | Master: make a release condition |
| cmd_req | input | 1 | Master: put a command condition before the next frame |
| auto_ack_en | input | 1 | Acknowledge every received frame |
| ack_req | input | 1 | Acknowledge the next frame once |
| busy_en | input | 1 | Slave: hold busy after the acknowledge |
| flag_clr | input | 1 | Clear all flags |
| rel_trig | output | 1 | Release condition generated |
| cmd_trig | output | 1 | Command condition generated |
| ack_trig | output | 1 | Acknowledge driven by this device |
| rel_det | output | 1 | Release condition seen |
| cmd_det | output | 1 | Command condition seen |
| ack_det | output | 1 | Acknowledge seen |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when rx_data updates |
| rx_kind | output | 2 | Frame class of rx_data |

## Verification
The assertions assume that no device starts a frame with a byte preloaded while markers are being made. A slave's tx_we therefore comes only while it is busy, after the acknowledge and before the master's next clock. Under that assumption a device's own data drive never changes during a clock-high interval. The assertions also assume a clock half-period of at least four system cycles, so that the synchroniser delay fits inside each phase. The stimulus uses one master and one slave on a wired bus, with the default half-period. It sends markers only while the slave has no byte pending and writes the slave's byte only during a busy hold.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    KIND_DATA = 2'b00,
    KIND_CMD  = 2'b01,
    KIND_ADDR = 2'b10
  } frame_kind_e;

  // Class of a frame from the marker flags held when it completes.
  function automatic frame_kind_e frame_kind(input logic rel_seen, input logic cmd_seen);
    if (cmd_seen && rel_seen) return KIND_ADDR;
    if (cmd_seen) return KIND_CMD;
    return KIND_DATA;
  endfunction

  // Pull-low request for bit number pos (0 = MSB) of a byte.
  function automatic logic zero_bit(input logic [DATA_W-1:0] v, input int unsigned pos);
    return ~v[DATA_W-1-pos];
  endfunction
endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
  parameter int STAGES = 2,
  parameter int CH     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] raw,
  output logic [CH-1:0] now_v,
  output logic [CH-1:0] prev_v
);
  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [STAGES:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-1:0], raw[c]};
    end
    assign now_v[c]  = pipe[STAGES-1];
    assign prev_v[c] = pipe[STAGES];
  end
endmodule

// File: rtl/sbus_master_seq.sv
module sbus_master_seq #(
  parameter int HALF = 8,
  parameter int DW   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic rel_req,
  input  logic cmd_req,
  input  logic tx_we,
  input  logic sb_s,
  output logic sck_drv,
  output logic fr_lo,
  output logic rel_go,
  output logic cmd_go,
  output logic wait_ready
);
  localparam int TW = (HALF > 2) ? $clog2(HALF) : 1;
  localparam int BW = $clog2(DW + 1);
  localparam logic [TW-1:0] T_LOAD = TW'(HALF - 1);
  localparam logic [BW-1:0] B_LAST = BW'(DW);

  typedef enum logic [3:0] {
    S_IDLE, S_REL_A, S_REL_B, S_REL_C, S_REL_D, S_CMD, S_LO, S_HI, S_POST, S_WAIT
  } mst_e;

  mst_e          st;
  logic [TW-1:0] tmr;
  logic [BW-1:0] bitn;
  logic          cmd_pend, go_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; bitn <= '0;
      cmd_pend <= 1'b0; go_pend <= 1'b0; rel_go <= 1'b0; cmd_go <= 1'b0;
    end else begin
      rel_go <= 1'b0;
      cmd_go <= 1'b0;
      if (cmd_req && enable) cmd_pend <= 1'b1;
      if (tx_we && enable)   go_pend  <= 1'b1;
      case (st)
        S_IDLE: begin
          if (enable && rel_req) begin
            st <= S_REL_A; tmr <= T_LOAD; rel_go <= 1'b1;
          end else if (enable && (go_pend || tx_we)) begin
            go_pend <= 1'b0; tmr <= T_LOAD; bitn <= '0;
            if (cmd_pend || cmd_req) begin
              st <= S_CMD; cmd_pend <= 1'b0; cmd_go <= 1'b1;
            end else begin
              st <= S_LO;
            end
          end
        end
        S_WAIT: if (sb_s) st <= S_IDLE;
        default: begin
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else begin
            tmr <= T_LOAD;
            case (st)
              S_REL_A: st <= S_REL_B;
              S_REL_B: st <= S_REL_C;
              S_REL_C: st <= S_REL_D;
              S_REL_D: st <= S_IDLE;
              S_CMD:   st <= S_LO;
              S_LO:    st <= S_HI;
              S_HI: begin
                if (bitn == B_LAST) st <= S_POST;
                else begin bitn <= bitn + 1'b1; st <= S_LO; end
              end
              S_POST:  st <= S_WAIT;
              default: st <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  assign sck_drv    = !(st inside {S_REL_A, S_REL_B, S_LO, S_POST, S_WAIT});
  assign fr_lo      = st inside {S_REL_B, S_REL_C, S_CMD};
  assign wait_ready = (st == S_WAIT);
endmodule

// File: rtl/sbus_shifter.sv
module sbus_shifter import sbus_pkg::*; #(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_master,
  input  logic          ev_rise,
  input  logic          ev_fall,
  input  logic          ev_frame,
  input  logic          sb_s,
  input  logic          tx_load,
  input  logic [DW-1:0] tx_data,
  input  logic          ack_en,
  input  logic          busy_en,
  output logic          data_lo,
  output logic          ack_lo,
  output logic          busy_lo,
  output logic          ack_drv,
  output logic          ack_seen,
  output logic          rx_done,
  output logic [DW-1:0] rx_byte
);
  localparam int CW = $clog2(DW + 2);
  localparam logic [CW-1:0] C_LASTBIT = CW'(DW - 1);
  localparam logic [CW-1:0] C_ACK     = CW'(DW);
  localparam logic [CW-1:0] C_POST    = CW'(DW + 1);

  logic [CW-1:0] cnt;
  logic [DW-1:0] txr, rxr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; txr <= '1; rxr <= '0; rx_byte <= '0;
      data_lo <= 1'b0; ack_lo <= 1'b0; busy_lo <= 1'b0;
      ack_drv <= 1'b0; ack_seen <= 1'b0; rx_done <= 1'b0;
    end else begin
      ack_drv  <= 1'b0;
      ack_seen <= 1'b0;
      rx_done  <= 1'b0;
      if (!busy_en) busy_lo <= 1'b0;
      if (ev_frame) begin
        cnt <= '0; data_lo <= 1'b0; ack_lo <= 1'b0;
      end else if (ev_rise) begin
        if (cnt < C_ACK) begin
          rxr <= {rxr[DW-2:0], sb_s};
          cnt <= cnt + 1'b1;
          if (cnt == C_LASTBIT) begin
            rx_byte <= {rxr[DW-2:0], sb_s};
            rx_done <= 1'b1;
          end
        end else if (cnt == C_ACK) begin
          ack_seen <= !sb_s;
          cnt      <= C_POST;
        end else begin
          cnt <= '0;
        end
      end else if (ev_fall) begin
        if (cnt < C_ACK) begin
          data_lo <= zero_bit(txr, 32'(cnt));
        end else if (cnt == C_ACK) begin
          data_lo <= 1'b0;
          ack_lo  <= ack_en;
          ack_drv <= ack_en;
          txr     <= '1;
        end else begin
          ack_lo  <= 1'b0;
          busy_lo <= busy_en && !is_master;
        end
      end
      if (tx_load) begin
        txr     <= tx_data;
        busy_lo <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl import sbus_pkg::*; #(
  parameter int HALF        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  logic              sck_in,
  output logic              sck_out,
  input  logic              sb_in,
  output logic              sb_pull,
  input  logic              tx_we,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rel_req,
  input  logic              cmd_req,
  input  logic              auto_ack_en,
  input  logic              ack_req,
  input  logic              busy_en,
  input  logic              flag_clr,
  output logic              rel_trig,
  output logic              cmd_trig,
  output logic              ack_trig,
  output logic              rel_det,
  output logic              cmd_det,
  output logic              ack_det,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic [1:0]        rx_kind
);
  logic [1:0] now_v, prev_v;
  sbus_sync #(.STAGES(SYNC_STAGES), .CH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({sb_in, sck_in}), .now_v(now_v), .prev_v(prev_v)
  );

  // Named line events, also watched by the bound checker.
  logic sck_s, sck_q, sb_s, sb_q;
  logic ev_rel, ev_cmd, ev_rise, ev_fall;
  assign sck_s   = now_v[0];
  assign sck_q   = prev_v[0];
  assign sb_s    = now_v[1];
  assign sb_q    = prev_v[1];
  assign ev_rel  = sck_s && sck_q && sb_s && !sb_q;
  assign ev_cmd  = sck_s && sck_q && !sb_s && sb_q;
  assign ev_rise = sck_s && !sck_q;
  assign ev_fall = !sck_s && sck_q;

  logic fr_lo, rel_go, cmd_go, mst_wait;
  sbus_master_seq #(.HALF(HALF), .DW(DATA_W)) u_mseq (
    .clk(clk), .rst_n(rst_n), .enable(is_master), .rel_req(rel_req), .cmd_req(cmd_req),
    .tx_we(tx_we), .sb_s(sb_s), .sck_drv(sck_out), .fr_lo(fr_lo),
    .rel_go(rel_go), .cmd_go(cmd_go), .wait_ready(mst_wait)
  );

  logic ack_pend, ack_en;
  logic data_lo, ack_lo, busy_lo, ack_drv, ack_seen, rx_done;
  logic [DATA_W-1:0] rx_byte;
  assign ack_en = auto_ack_en || ack_pend;

  sbus_shifter #(.DW(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .ev_frame(ev_rel || ev_cmd), .sb_s(sb_s), .tx_load(tx_we), .tx_data(tx_data),
    .ack_en(ack_en), .busy_en(busy_en), .data_lo(data_lo), .ack_lo(ack_lo),
    .busy_lo(busy_lo), .ack_drv(ack_drv), .ack_seen(ack_seen), .rx_done(rx_done),
    .rx_byte(rx_byte)
  );

  assign sb_pull = fr_lo || data_lo || ack_lo || busy_lo;

  frame_kind_e kind_q;
  assign rx_kind = kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_trig <= 1'b0; cmd_trig <= 1'b0; ack_trig <= 1'b0;
      rel_det  <= 1'b0; cmd_det  <= 1'b0; ack_det  <= 1'b0;
      ack_pend <= 1'b0; rx_valid <= 1'b0; rx_data  <= '0; kind_q <= KIND_DATA;
    end else begin
      if (flag_clr) begin
        rel_trig <= 1'b0; cmd_trig <= 1'b0; ack_trig <= 1'b0;
        rel_det  <= 1'b0; cmd_det  <= 1'b0; ack_det  <= 1'b0;
      end
      if (rel_go)   rel_trig <= 1'b1;
      if (cmd_go)   cmd_trig <= 1'b1;
      if (ack_drv)  ack_trig <= 1'b1;
      if (ack_seen) ack_det  <= 1'b1;
      if (ev_cmd)   cmd_det  <= 1'b1;
      if (ev_rel) begin
        rel_det <= 1'b1;
        cmd_det <= 1'b0;
      end
      if (ack_req)      ack_pend <= 1'b1;
      else if (ack_drv) ack_pend <= 1'b0;
      rx_valid <= rx_done;
      if (rx_done) begin
        rx_data <= rx_byte;
        kind_q  <= frame_kind(rel_det, cmd_det);
      end
    end
  end
endmodule

// File: rtl/sbus_ctrl_chk.sv
module sbus_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       is_master,
  input logic       sck_out,
  input logic       sck_s,
  input logic       sck_q,
  input logic       sb_s,
  input logic       data_lo,
  input logic       ack_lo,
  input logic       busy_lo,
  input logic       ev_rel,
  input logic       rel_det,
  input logic       cmd_det,
  input logic       flag_clr,
  input logic       rx_valid,
  input logic [1:0] rx_kind,
  input logic       mst_wait
);
  assert_slave_sck_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> sck_out);

  assert_drive_still_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_s && sck_q) |-> $stable(data_lo));

  assert_rel_drops_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rel |=> (rel_det && !cmd_det));

  assert_clear_rel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !ev_rel) |=> !rel_det);

  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_kind_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_kind != 2'b11));

  assert_master_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_wait && !sb_s) |=> !sck_out);

  assert_busy_slave_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_lo |-> !is_master);

  assert_ack_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_lo |-> !busy_lo);
endmodule

bind sbus_ctrl sbus_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .is_master(is_master), .sck_out(sck_out),
  .sck_s(sck_s), .sck_q(sck_q), .sb_s(sb_s), .data_lo(data_lo), .ack_lo(ack_lo),
  .busy_lo(busy_lo), .ev_rel(ev_rel), .rel_det(rel_det), .cmd_det(cmd_det),
  .flag_clr(flag_clr), .rx_valid(rx_valid), .rx_kind(rx_kind), .mst_wait(mst_wait)
);

// File: tb/sbus_ctrl_bench.sv
module sbus_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  // master-side stimulus
  logic m_tx_we = 0, m_rel = 0, m_cmd = 0, m_auto = 0, m_ackr = 0, m_clr = 0;
  logic [7:0] m_txd = 8'h00;
  // slave-side stimulus
  logic s_tx_we = 0, s_auto = 0, s_ackr = 0, s_busy = 0, s_clr = 0;
  logic [7:0] s_txd = 8'h00;

  logic m_sck, s_sck, m_pull, s_pull;
  logic sck_line, sb_line;
  assign sck_line = m_sck & s_sck;
  assign sb_line  = !(m_pull || s_pull);

  logic m_rt, m_ct, m_at, m_rd, m_cd, m_ad, m_rv;
  logic s_rt, s_ct, s_at, s_rd, s_cd, s_ad, s_rv;
  logic [7:0] m_rx, s_rx;
  logic [1:0] m_kind, s_kind;

  sbus_ctrl u_sbus_ctrl (
    .clk(clk), .rst_n(rst_n), .is_master(1'b1), .sck_in(sck_line), .sck_out(m_sck),
    .sb_in(sb_line), .sb_pull(m_pull), .tx_we(m_tx_we), .tx_data(m_txd),
    .rel_req(m_rel), .cmd_req(m_cmd), .auto_ack_en(m_auto), .ack_req(m_ackr),
    .busy_en(1'b0), .flag_clr(m_clr), .rel_trig(m_rt), .cmd_trig(m_ct), .ack_trig(m_at),
    .rel_det(m_rd), .cmd_det(m_cd), .ack_det(m_ad), .rx_data(m_rx), .rx_valid(m_rv),
    .rx_kind(m_kind)
  );

  sbus_ctrl u_peer (
    .clk(clk), .rst_n(rst_n), .is_master(1'b0), .sck_in(sck_line), .sck_out(s_sck),
    .sb_in(sb_line), .sb_pull(s_pull), .tx_we(s_tx_we), .tx_data(s_txd),
    .rel_req(1'b0), .cmd_req(1'b0), .auto_ack_en(s_auto), .ack_req(s_ackr),
    .busy_en(s_busy), .flag_clr(s_clr), .rel_trig(s_rt), .cmd_trig(s_ct), .ack_trig(s_at),
    .rel_det(s_rd), .cmd_det(s_cd), .ack_det(s_ad), .rx_data(s_rx), .rx_valid(s_rv),
    .rx_kind(s_kind)
  );

  int n_chk = 0, n_fail = 0;
  int s_valid_cnt = 0;
  int mon_n = 0;
  logic [8:0] mon = '0;  // mon[8] = first sampled bit, mon[0] = ninth clock level

  always @(posedge sck_line) begin
    if (mon_n < 9) begin
      mon[8 - mon_n] = sb_line;
      mon_n = mon_n + 1;
    end
  end

  always @(posedge clk) if (s_rv) s_valid_cnt = s_valid_cnt + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_release();
    @(negedge clk); m_rel = 1;
    @(negedge clk); m_rel = 0;
    idle(60);
  endtask

  task automatic m_frame(input logic [7:0] d, input bit with_cmd);
    mon_n = 0; s_valid_cnt = 0;
    @(negedge clk); m_txd = d; m_tx_we = 1; m_cmd = with_cmd;
    @(negedge clk); m_tx_we = 0; m_cmd = 0;
    idle(260);
  endtask

  task automatic clear_both();
    @(negedge clk); m_clr = 1; s_clr = 1;
    @(negedge clk); m_clr = 0; s_clr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1;
    idle(4);
    // R1 reset state
    chk("R1 master flags", {m_rt, m_ct, m_at, m_rd, m_cd, m_ad}, 0);
    chk("R1 slave flags",  {s_rt, s_ct, s_at, s_rd, s_cd, s_ad}, 0);
    chk("R1 lines idle",   {sck_line, sb_line, m_pull}, 3'b110);
    chk("R11 slave sck",   s_sck, 1);

    // R2 release condition
    m_release();
    chk("R2 rel_trig", m_rt, 1);
    chk("R2 rel_det both", {m_rd, s_rd}, 2'b11);
    chk("R2 no cmd_det", s_cd, 0);

    // R4/R5/R6/R7 address frame: release, command, byte
    s_auto = 1;
    m_frame(8'hA5, 1);
    chk("R4 cmd_trig", m_ct, 1);
    chk("R4 cmd_det slave", s_cd, 1);
    chk("R5 address kind", s_kind, 2'b10);
    chk("R5 one valid", s_valid_cnt, 1);
    chk("R6 slave rx", s_rx, 8'hA5);
    chk("R6 msb first on line", mon[8:1], 8'hA5);
    chk("R7 ack low ninth", mon[0], 0);
    chk("R7 ack_det master", m_ad, 1);
    chk("R7 ack_trig slave", s_at, 1);

    // R3 release clears command detect
    m_release();
    chk("R3 cmd_det cleared", {s_rd, s_cd}, 2'b10);

    // R10 flag clear
    clear_both();
    @(negedge clk);
    chk("R10 master cleared", {m_rt, m_ct, m_at, m_rd, m_cd, m_ad}, 0);
    chk("R10 slave cleared",  {s_rt, s_ct, s_at, s_rd, s_cd, s_ad}, 0);

    // R5 command frame without release
    m_frame(8'h3C, 1);
    chk("R5 command kind", s_kind, 2'b01);
    chk("R6 command byte", s_rx, 8'h3C);

    // R5/R6/R7 sweep of data frames
    clear_both();
    for (int i = 0; i < 20; i++) begin
      logic [7:0] d;
      d = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'((i * 53 + 7) & 255);
      m_frame(d, 0);
      chk("R5 data kind", s_kind, 2'b00);
      chk("R5 one valid", s_valid_cnt, 1);
      chk("R6 slave rx sweep", s_rx, d);
      chk("R6 master rx wired-and", m_rx, d);
      chk("R6 line order", mon[8:1], d);
      chk("R7 ack each", mon[0], 0);
    end

    // R7 no acknowledge, then one-shot software acknowledge
    s_auto = 0;
    clear_both();
    m_frame(8'h66, 0);
    chk("R7 no ack line", mon[0], 1);
    chk("R7 no ack_det", m_ad, 0);
    chk("R7 no ack_trig", s_at, 0);
    @(negedge clk); s_ackr = 1;
    @(negedge clk); s_ackr = 0;
    m_frame(8'h99, 0);
    chk("R7 sw ack line", mon[0], 0);
    chk("R7 sw ack flags", {s_at, m_ad}, 2'b11);
    m_frame(8'h77, 0);
    chk("R7 sw ack once", mon[0], 1);

    // R8/R9 busy hold released by clearing busy_en
    s_auto = 1; s_busy = 1;
    m_frame(8'h81, 0);
    chk("R8 busy holds sb", sb_line, 0);
    chk("R8 master holds sck", sck_line, 0);
    idle(100);
    chk("R8 still held", {sck_line, sb_line}, 2'b00);
    chk("R6 byte before busy", s_rx, 8'h81);
    @(negedge clk); s_busy = 0;
    idle(30);
    chk("R9 ready after busy_en", {sck_line, sb_line}, 2'b11);

    // R9 busy released by a transmit write, then slave sends
    s_busy = 1;
    m_frame(8'h42, 0);
    chk("R8 busy again", {sck_line, sb_line}, 2'b00);
    @(negedge clk); s_txd = 8'h5A; s_tx_we = 1;
    @(negedge clk); s_tx_we = 0;
    idle(30);
    chk("R9 ready after write", {sck_line, sb_line}, 2'b11);
    s_busy = 0; s_auto = 0; m_auto = 1;
    clear_both();
    m_frame(8'hFF, 0);
    chk("R6 master receives slave byte", m_rx, 8'h5A);
    chk("R6 line carries slave byte", mon[8:1], 8'h5A);
    chk("R7 master acks", {m_at, s_ad}, 2'b11);
    chk("R11 slave sck end", s_sck, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule